// File: doc/BRIEF.md
# Masked Scalar Half-Precision Adder

This block is the execution datapath for a scalar half-precision add. Each cycle it takes two 128-bit source vectors and the current destination vector. It adds the lowest 16-bit lane of the two sources as IEEE binary16 values and rounds the sum in one of four directions. It then places the sum into a 128-bit result whose upper lanes come from source 1. One registered stage separates the inputs from `res_vec` and `exc_flags`.

A one-bit lane mask decides whether the sum is written. When the lane is disabled, the low lane is either cleared or left at the old destination value, as the zeroing select chooses. The rounding direction normally comes from a control-register field. A per-operation field overrides it when that override is enabled and source 2 comes from a register. While the override is in effect, no exception flags are reported. Subnormal operands and results are handled exactly, with no flushing.

Top module: `hadd_scalar_unit`

## Requirements
- R1: With `wmask_on` low or `wmask_bit` high, `res_vec[15:0]` one clock after the inputs is the binary16 sum of `src1_vec[15:0]` and `src2_vec[15:0]`, rounded in the selected direction.
- R2: With `wmask_on` high, `wmask_bit` low and `zero_fill` high, `res_vec[15:0]` is 16'h0000.
- R3: With `wmask_on` high, `wmask_bit` low and `zero_fill` low, `res_vec[15:0]` equals `dst_prev[15:0]`.
- R4: `res_vec[127:16]` always equals `src1_vec[127:16]` of the same operation, whatever the mask state.
- R5: The rounding field is `emb_rnd_mode` when both `emb_rnd_on` and `src2_reg` are high, otherwise `ctl_rnd_mode`. Encoding: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R6: The flag bits are `exc_flags[0]` invalid, [1] denormal, [2] overflow, [3] underflow and [4] precision. All five read zero when the override of R5 is in effect, and also when the lane is disabled by the mask.
- R7: If either operand is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 9 clear), the sum is 16'h7E00 and invalid is raised. The sum is also 16'h7E00 with invalid raised for infinities of opposite sign. Otherwise a quiet NaN operand is returned unchanged, source 1 first.
- R8: An infinity added to a finite value, or to an infinity of the same sign, returns that infinity with no flag except denormal.
- R9: An exact zero sum of opposite-signed operands is 16'h0000, except toward minus infinity, where it is 16'h8000. Two zeros of the same sign keep that sign.
- R10: When the rounded magnitude reaches 16'h7C00, overflow and precision are raised. The result is infinity for nearest-even and for a direction that rounds away from zero; otherwise it is 16'h7BFF, with the sign of the sum.
- R11: Subnormal operands and results are exact. Denormal is raised when either operand is subnormal and neither is a NaN.
- R12: Precision is raised whenever rounding discards nonzero bits. Underflow reads zero, because any sum below the smallest normal is exact.
- R13: While `rst_n` is low at a clock edge, `res_vec` and `exc_flags` become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src1_vec | input | 128 | First source vector; low lane is an addend, upper lanes pass through |
| src2_vec | input | 128 | Second source vector; only the low lane is used |
| dst_prev | input | 128 | Current destination value, used for merging |
| wmask_on | input | 1 | A lane mask applies to this operation |
| wmask_bit | input | 1 | Mask bit for the low lane |
| zero_fill | input | 1 | 1 clears a disabled lane, 0 keeps the old value |
| src2_reg | input | 1 | Source 2 came from a register |
| emb_rnd_on | input | 1 | Per-operation rounding override requested |
| emb_rnd_mode | input | 2 | Per-operation rounding direction |
| ctl_rnd_mode | input | 2 | Control-register rounding direction |
| res_vec | output | 128 | Registered result vector |
| exc_flags | output | 5 | Registered exception flags |

## Verification
In a single operation, the rounding override both changes the direction and silences the flags. Both effects can fall on a sum that overflows or rounds inexactly. The sweep provokes this by raising the override on every fifth vector, while the operands span the full exponent range, and by holding some of those vectors with source 2 marked as memory. Each such vector is judged on both effects: the low lane must carry the sum rounded in the override direction with all flags at zero, and with `src2_reg` low it must instead follow the control-register direction with the flags reported.

// File: rtl/hadd_pkg.sv
// Shared constants and types for the scalar binary16 adder.
// Assumes IEEE binary16 layout: 1 sign, 5 exponent, 10 fraction bits.
package hadd_pkg;
    localparam int HW     = 16;
    localparam int EW     = 5;
    localparam int MW     = 10;
    localparam int SIG_W  = MW + 1;
    // Largest alignment shift is (max finite exponent field - 1).
    localparam int ALN_W  = SIG_W + (2 ** EW) - 3;
    localparam int SUM_W  = ALN_W + 1;
    localparam int POS_W  = $clog2(SUM_W);
    localparam int FLAG_W = 5;

    localparam logic [HW-1:0] QNAN_DEF = 16'h7E00;
    localparam logic [HW-2:0] MAX_FIN  = 15'h7BFF;
    localparam logic [HW-2:0] INF_MAG  = 15'h7C00;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_t;

    // Packed so that inv is bit 0 and prec is bit 4.
    typedef struct packed {
        logic prec;
        logic unf;
        logic ovf;
        logic dnm;
        logic inv;
    } hflags_t;
endpackage

// File: rtl/hadd_rm_sel.sv
// Picks the rounding direction for one operation.
// Assumes the per-operation override is only honoured for register sources.
module hadd_rm_sel
    import hadd_pkg::*;
(
    input  logic       ovr_req,
    input  logic       src_is_reg,
    input  logic [1:0] ovr_mode,
    input  logic [1:0] ctl_mode,
    output rmode_t     rm,
    output logic       ovr_active
);
    // Override applies only when requested and the operand is a register.
    always_comb begin
        ovr_active = ovr_req & src_is_reg;
        rm         = rmode_t'(ovr_active ? ovr_mode : ctl_mode);
    end
endmodule

// File: rtl/hadd_core.sv
// Combinational IEEE binary16 adder with four rounding directions.
// Both operands are aligned exactly onto a fixed-point grid whose unit is
// the smallest subnormal, so no bits are lost before the final round.
// Assumes no flush-to-zero; tiny sums are always exact.
module hadd_core
    import hadd_pkg::*;
(
    input  logic [HW-1:0] op_a,
    input  logic [HW-1:0] op_b,
    input  rmode_t        rm,
    output logic [HW-1:0] sum,
    output hflags_t       fl
);
    logic          sa, sb;
    logic [EW-1:0] ea, eb;
    logic [MW-1:0] ma, mb;
    logic          a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_sub, b_sub;
    logic [EW-1:0] sha, shb;
    logic [SUM_W-1:0] al_a, al_b;

    assign sa = op_a[HW-1];
    assign sb = op_b[HW-1];
    assign ea = op_a[HW-2:MW];
    assign eb = op_b[HW-2:MW];
    assign ma = op_a[MW-1:0];
    assign mb = op_b[MW-1:0];

    // Classify each operand into NaN, infinity and subnormal classes.
    always_comb begin
        a_nan  = (&ea) & (|ma);
        b_nan  = (&eb) & (|mb);
        a_snan = a_nan & ~ma[MW-1];
        b_snan = b_nan & ~mb[MW-1];
        a_inf  = (&ea) & ~(|ma);
        b_inf  = (&eb) & ~(|mb);
        a_sub  = (ea == '0) & (|ma);
        b_sub  = (eb == '0) & (|mb);
    end

    // Place both significands on the common fixed-point grid.
    always_comb begin
        sha  = (ea == '0) ? '0 : ea - EW'(1);
        shb  = (eb == '0) ? '0 : eb - EW'(1);
        al_a = SUM_W'({(ea != '0), ma}) << sha;
        al_b = SUM_W'({(eb != '0), mb}) << shb;
    end

    logic             same_sign;
    logic [SUM_W-1:0] mag;
    logic             msign;

    // Signed-magnitude add: larger magnitude supplies the sign.
    always_comb begin
        same_sign = (sa == sb);
        if (same_sign) begin
            mag   = al_a + al_b;
            msign = sa;
        end else if (al_a >= al_b) begin
            mag   = al_a - al_b;
            msign = sa;
        end else begin
            mag   = al_b - al_a;
            msign = sb;
        end
    end

    logic [POS_W-1:0] lead;

    // Locate the most significant set bit of the exact magnitude.
    always_comb begin
        lead = '0;
        for (int i = 0; i < SUM_W; i++) begin
            if (mag[i]) lead = POS_W'(i);
        end
    end

    logic [POS_W-1:0] shamt;
    logic [SIG_W-1:0] keep;
    logic             rbit, sticky, inexact, inc;
    logic [HW:0]      enc;

    // Cut the magnitude to 11 bits, derive round/sticky, and encode.
    always_comb begin
        shamt  = '0;
        keep   = '0;
        rbit   = 1'b0;
        sticky = 1'b0;
        if (lead > POS_W'(MW)) begin
            shamt  = lead - POS_W'(MW);
            keep   = SIG_W'(mag >> shamt);
            rbit   = mag[shamt - POS_W'(1)];
            sticky = |(mag & ((SUM_W'(1) << (shamt - POS_W'(1))) - SUM_W'(1)));
        end
        inexact = rbit | sticky;
        unique case (rm)
            RM_NEAR: inc = rbit & (sticky | keep[0]);
            RM_DOWN: inc = inexact & msign;
            RM_UP:   inc = inexact & ~msign;
            default: inc = 1'b0;
        endcase
        // Exponent field is shamt+1; the hidden bit of keep supplies the +1,
        // and a rounding carry ripples into the exponent on its own.
        if (shamt == '0) enc = (HW+1)'(mag[SIG_W-1:0]);
        else             enc = ((HW+1)'(shamt) << MW) + (HW+1)'(keep) + (HW+1)'(inc);
    end

    logic to_inf;

    // Special values first, then zero, overflow and ordinary results.
    always_comb begin
        fl     = '0;
        fl.dnm = (a_sub | b_sub) & ~a_nan & ~b_nan;
        to_inf = (rm == RM_NEAR) | ((rm == RM_UP) & ~msign) | ((rm == RM_DOWN) & msign);
        if (a_snan | b_snan) begin
            sum    = QNAN_DEF;
            fl.inv = 1'b1;
        end else if (a_nan) begin
            sum = op_a;
        end else if (b_nan) begin
            sum = op_b;
        end else if (a_inf & b_inf & ~same_sign) begin
            sum    = QNAN_DEF;
            fl.inv = 1'b1;
        end else if (a_inf) begin
            sum = op_a;
        end else if (b_inf) begin
            sum = op_b;
        end else if (mag == '0) begin
            sum = {(same_sign ? sa : (rm == RM_DOWN)), {(HW-1){1'b0}}};
        end else if (enc >= (HW+1)'(INF_MAG)) begin
            sum     = {msign, (to_inf ? INF_MAG : MAX_FIN)};
            fl.ovf  = 1'b1;
            fl.prec = 1'b1;
        end else begin
            sum     = {msign, enc[HW-2:0]};
            fl.prec = inexact;
        end
    end
endmodule

// File: rtl/hadd_merge.sv
// Builds the result vector from the adder output and the lane mask.
// Assumes only the lowest lane is computed; all others come from source 1.
module hadd_merge
    import hadd_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]  src1_vec,
    input  logic [VEC_W-1:0]  dst_prev,
    input  logic [HW-1:0]     lane_sum,
    input  hflags_t           lane_fl,
    input  logic              mask_on,
    input  logic              mask_bit,
    input  logic              zero_fill,
    input  logic              flags_quiet,
    output logic [VEC_W-1:0]  out_vec,
    output logic [FLAG_W-1:0] out_flags
);
    localparam int UPPER_W = VEC_W - HW;

    logic lane_live;

    // Choose the low lane and gate the flags by mask and override.
    always_comb begin
        lane_live = ~mask_on | mask_bit;
        out_vec[VEC_W-1:HW] = src1_vec[VEC_W-1:HW];
        if (lane_live)      out_vec[HW-1:0] = lane_sum;
        else if (zero_fill) out_vec[HW-1:0] = '0;
        else                out_vec[HW-1:0] = dst_prev[HW-1:0];
        out_flags = (lane_live & ~flags_quiet) ? FLAG_W'(lane_fl) : '0;
    end

    if (UPPER_W < 1) begin : g_bad_width
        $error("hadd_merge: VEC_W must exceed one lane");
    end
endmodule

// File: rtl/hadd_scalar_unit.sv
// Top of the masked scalar binary16 adder: rounding select, adder,
// lane merge and one output register stage.
// Assumes synchronous active-low reset; one operation per clock.
module hadd_scalar_unit
    import hadd_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VEC_W-1:0]  src1_vec,
    input  logic [VEC_W-1:0]  src2_vec,
    input  logic [VEC_W-1:0]  dst_prev,
    input  logic              wmask_on,
    input  logic              wmask_bit,
    input  logic              zero_fill,
    input  logic              src2_reg,
    input  logic              emb_rnd_on,
    input  logic [1:0]        emb_rnd_mode,
    input  logic [1:0]        ctl_rnd_mode,
    output logic [VEC_W-1:0]  res_vec,
    output logic [FLAG_W-1:0] exc_flags
);
    rmode_t            rm;
    logic              ovr_active;
    logic [HW-1:0]     lane_sum;
    hflags_t           lane_fl;
    logic [VEC_W-1:0]  next_vec;
    logic [FLAG_W-1:0] next_flags;

    hadd_rm_sel u_rm (
        .ovr_req    (emb_rnd_on),
        .src_is_reg (src2_reg),
        .ovr_mode   (emb_rnd_mode),
        .ctl_mode   (ctl_rnd_mode),
        .rm         (rm),
        .ovr_active (ovr_active)
    );

    hadd_core u_core (
        .op_a (src1_vec[HW-1:0]),
        .op_b (src2_vec[HW-1:0]),
        .rm   (rm),
        .sum  (lane_sum),
        .fl   (lane_fl)
    );

    hadd_merge #(.VEC_W(VEC_W)) u_merge (
        .src1_vec    (src1_vec),
        .dst_prev    (dst_prev),
        .lane_sum    (lane_sum),
        .lane_fl     (lane_fl),
        .mask_on     (wmask_on),
        .mask_bit    (wmask_bit),
        .zero_fill   (zero_fill),
        .flags_quiet (ovr_active),
        .out_vec     (next_vec),
        .out_flags   (next_flags)
    );

    // Output register stage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vec   <= '0;
            exc_flags <= '0;
        end else begin
            res_vec   <= next_vec;
            exc_flags <= next_flags;
        end
    end

    logic primed;

    // Marks that the previous edge loaded real data, for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    AST_UPPER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> res_vec[VEC_W-1:HW] == $past(src1_vec[VEC_W-1:HW])); // R4
    AST_ZERO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(wmask_on && !wmask_bit && zero_fill)) |-> res_vec[HW-1:0] == '0); // R2
    AST_MERGE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(wmask_on && !wmask_bit && !zero_fill)) |-> res_vec[HW-1:0] == $past(dst_prev[HW-1:0])); // R3
    AST_QUIET_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(emb_rnd_on && src2_reg)) |-> exc_flags == '0); // R6
    AST_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(wmask_on && !wmask_bit)) |-> exc_flags == '0); // R6
    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flags[2] |-> exc_flags[4]); // R10
endmodule

// File: tb/sim_hadd_scalar_unit.sv
module sim_hadd_scalar_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] src1_vec = '0, src2_vec = '0, dst_prev = '0;
    logic         wmask_on = 1'b0, wmask_bit = 1'b0, zero_fill = 1'b0;
    logic         src2_reg = 1'b0, emb_rnd_on = 1'b0;
    logic [1:0]   emb_rnd_mode = '0, ctl_rnd_mode = '0;
    logic [127:0] res_vec;
    logic [4:0]   exc_flags;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hadd_scalar_unit u0 (
        .clk(clk), .rst_n(rst_n), .src1_vec(src1_vec), .src2_vec(src2_vec),
        .dst_prev(dst_prev), .wmask_on(wmask_on), .wmask_bit(wmask_bit),
        .zero_fill(zero_fill), .src2_reg(src2_reg), .emb_rnd_on(emb_rnd_on),
        .emb_rnd_mode(emb_rnd_mode), .ctl_rnd_mode(ctl_rnd_mode),
        .res_vec(res_vec), .exc_flags(exc_flags)
    );

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Exact real value of a binary16 encoding.
    function automatic real hval(input logic [15:0] h);
        int  e;
        real m, v;
        e = int'(h[14:10]);
        m = real'(int'(h[9:0]));
        if (e == 0) v = m * (2.0 ** (-24));
        else        v = (1024.0 + m) * (2.0 ** (e - 25));
        return h[15] ? -v : v;
    endfunction

    // Reference sum and flags {prec,unf,ovf,dnm,inv}, from the requirements.
    task automatic ref_add(input logic [15:0] a, input logic [15:0] b, input logic [1:0] rm,
                           output logic [15:0] r, output logic [4:0] fl);
        logic an, bn, asn, bsn, ai, bi, s;
        real  x, mag, qf, fr;
        int   e, ifl, inc, enc;
        an  = (a[14:10] == 5'h1F) && (a[9:0] != 0);
        bn  = (b[14:10] == 5'h1F) && (b[9:0] != 0);
        asn = an && !a[9];
        bsn = bn && !b[9];
        ai  = (a[14:10] == 5'h1F) && (a[9:0] == 0);
        bi  = (b[14:10] == 5'h1F) && (b[9:0] == 0);
        fl  = '0;
        fl[1] = ((a[14:10] == 0 && a[9:0] != 0) || (b[14:10] == 0 && b[9:0] != 0)) && !an && !bn;
        if (asn || bsn)                    begin r = 16'h7E00; fl[0] = 1'b1; end
        else if (an)                       r = a;
        else if (bn)                       r = b;
        else if (ai && bi && a[15] != b[15]) begin r = 16'h7E00; fl[0] = 1'b1; end
        else if (ai)                       r = a;
        else if (bi)                       r = b;
        else begin
            x = hval(a) + hval(b);
            if (x == 0.0) begin
                r = {((a[15] == b[15]) ? a[15] : (rm == 2'b01)), 15'h0};
            end else begin
                s   = (x < 0.0);
                mag = s ? -x : x;
                if (mag < 2.0 ** (-14)) begin
                    r = {s, 15'($rtoi(mag * (2.0 ** 24)))};
                end else begin
                    e = -14;
                    while (mag >= 2.0 ** (e + 1)) e++;
                    qf  = mag * (2.0 ** (10 - e));
                    ifl = $rtoi($floor(qf));
                    fr  = qf - real'(ifl);
                    case (rm)
                        2'b00:   inc = (fr > 0.5 || (fr == 0.5 && (ifl % 2) == 1)) ? 1 : 0;
                        2'b01:   inc = (fr != 0.0 && s) ? 1 : 0;
                        2'b10:   inc = (fr != 0.0 && !s) ? 1 : 0;
                        default: inc = 0;
                    endcase
                    enc   = (e + 14) * 1024 + ifl + inc;
                    fl[4] = (fr != 0.0);
                    if (enc >= 31744) begin
                        fl[2] = 1'b1;
                        fl[4] = 1'b1;
                        if (rm == 2'b00 || (rm == 2'b10 && !s) || (rm == 2'b01 && s))
                            r = {s, 15'h7C00};
                        else
                            r = {s, 15'h7BFF};
                    end else begin
                        r = {s, 15'(enc)};
                    end
                end
            end
        end
    endtask

    // Drive one operation, predict it, and compare one clock later.
    task automatic apply(input string tag, input logic [127:0] s1, input logic [127:0] s2,
                         input logic [127:0] dp, input logic me, input logic mb, input logic zf,
                         input logic s2r, input logic ee, input logic [1:0] erc, input logic [1:0] crc);
        logic [1:0]  rm;
        logic [15:0] r, lo;
        logic [4:0]  fl, ef;
        logic        live, quiet, bad;
        string       lt;
        @(negedge clk);
        src1_vec = s1; src2_vec = s2; dst_prev = dp;
        wmask_on = me; wmask_bit = mb; zero_fill = zf;
        src2_reg = s2r; emb_rnd_on = ee; emb_rnd_mode = erc; ctl_rnd_mode = crc;
        quiet = ee && s2r;                      // R5 selection
        rm    = quiet ? erc : crc;
        ref_add(s1[15:0], s2[15:0], rm, r, fl);
        live  = !me || mb;
        if (live)    begin lo = r;         lt = tag;  end
        else if (zf) begin lo = 16'h0000;  lt = "R2"; end
        else         begin lo = dp[15:0];  lt = "R3"; end
        ef = (live && !quiet) ? fl : 5'h0;      // R6 gating
        @(posedge clk);
        #1;
        vectors++;
        bad = 1'b0;
        if (res_vec[15:0] !== lo) begin
            bad = 1'b1;
            $display("FAIL %s low lane a=%h b=%h rm=%0d: got %h expected %h", lt, s1[15:0], s2[15:0], rm, res_vec[15:0], lo);
        end
        if (res_vec[127:16] !== s1[127:16]) begin
            bad = 1'b1;
            $display("FAIL R4 upper lanes: got %h expected %h", res_vec[127:16], s1[127:16]);
        end
        if (exc_flags !== ef) begin
            bad = 1'b1;
            $display("FAIL %s flags a=%h b=%h rm=%0d: got %b expected %b", (quiet || !live) ? "R6" : tag, s1[15:0], s2[15:0], rm, exc_flags, ef);
        end
        if (bad) miscompares++;
    endtask

    function automatic logic [15:0] op_a_of(input logic [7:0] k);
        return {k[7], k[6:2], {5{k[1:0]}}};
    endfunction

    function automatic logic [15:0] op_b_of(input logic [7:0] k);
        return {k[7], k[6:2], k[1:0], 8'(k * 8'd29)};
    endfunction

    function automatic logic [127:0] wide(input logic [15:0] lo);
        return {$urandom, $urandom, $urandom, $urandom[15:0], lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        wrap_up();
    end

    initial begin
        // R13: reset clears outputs even with live inputs present.
        src1_vec = {8{16'h3C00}}; src2_vec = {8{16'h7BFF}}; dst_prev = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (res_vec !== '0 || exc_flags !== '0) begin
            miscompares++;
            $display("FAIL R13 reset state: got %h/%b expected 0/0", res_vec, exc_flags);
        end
        rst_n = 1'b1;

        // R5: override direction differs from control direction.
        apply("R5", wide(16'h3C00), wide(16'h0001), wide(16'h1234), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 2'b00);
        apply("R5", wide(16'h3C00), wide(16'h0001), wide(16'h1234), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b00);
        apply("R5", wide(16'hBC00), wide(16'h8001), wide(16'h1234), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 2'b01);
        // R10: overflow in every direction and both signs.
        for (int m = 0; m < 4; m++) begin
            apply("R10", wide(16'h7BFF), wide(16'h7BFF), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'(m));
            apply("R10", wide(16'hFBFF), wide(16'hFBF0), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'(m));
        end
        apply("R10", wide(16'h7BFF), wide(16'h5000), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        // R9: exact cancellation in each direction, and same-sign zeros.
        for (int m = 0; m < 4; m++)
            apply("R9", wide(16'h3C00), wide(16'hBC00), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'(m));
        apply("R9", wide(16'h8000), wide(16'h8000), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        // R7: invalid cases and quiet NaN propagation.
        apply("R7", wide(16'h7C00), wide(16'hFC00), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        apply("R7", wide(16'h3C00), wide(16'h7D00), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        apply("R7", wide(16'h7E55), wide(16'hFE11), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        apply("R7", wide(16'h3C00), wide(16'hFE11), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        // R8: infinity arithmetic.
        apply("R8", wide(16'hFC00), wide(16'h0003), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        apply("R8", wide(16'h7C00), wide(16'h7C00), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        // R11: subnormal sums and the normal boundary.
        apply("R11", wide(16'h0001), wide(16'h0001), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        apply("R11", wide(16'h03FF), wide(16'h0001), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        apply("R11", wide(16'h0400), wide(16'h8001), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        // R12: nearest-even ties in both directions.
        apply("R12", wide(16'h3C00), wide(16'h1000), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        apply("R12", wide(16'h3C01), wide(16'h1000), '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        // R2, R3: disabled lane with an overflowing sum, flags must stay quiet.
        apply("R2", wide(16'h7BFF), wide(16'h7BFF), wide(16'hABCD), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00);
        apply("R3", wide(16'h7BFF), wide(16'h7BFF), wide(16'hABCD), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
        apply("R1", wide(16'h7BFF), wide(16'h7BFF), wide(16'hABCD), 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00);

        // R1: sweep operand pairs over all classes, mixing mask, mode and override.
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                apply("R1", wide(op_a_of(8'(i))), wide(op_b_of(8'(j))), wide(16'(i * 131 + j)),
                      (i % 4) != 3, (j % 7) != 0, ((i ^ j) & 1) == 1,
                      (j % 3) != 0, (j % 5) == 0, 2'(i + 1), 2'(i + j));
            end
        end
        wrap_up();
    end
endmodule